// File: doc/BRIEF.md
# PWM Timebase Counter

This block is the timebase of a PWM generator. A 16-bit counter advances on each cycle in which the clock-enable `tick` is high. It counts within a range set by a period value, in one of four modes: held, counting up, counting down, or alternating up and down. It reports its count and its present direction. It also raises one-cycle pulses when the count lands on zero (the zero event) and when it lands on the period (the period event). Compare logic further down the chip uses these to form its outputs.

Software controls the block with a single write strobe. The strobe carries a 3-bit start/stop command and a 2-bit counting mode. The command can start a free run, or start a run that halts by itself at the next zero or period event. On a counter that is already running, it can arm a halt at the next such event. A halted counter keeps its value and stays quiet until it is started again. The interface has no data stream, so every pin is plain control or status with no handshake.

Top module: `pwm_timebase`

## Requirements
- R1: After reset the count is 0, `dir_down` is 0, `tez` and `tep` are low, the counter is stopped and the mode is held (0); ticks then change nothing until a start command is written.
- R2: In mode 1 (up), each active tick moves the count 0,1,…,period and then back to 0, with `dir_down` low.
- R3: In mode 2 (down), each active tick moves the count period,…,1,0 and then reloads period; a count of 0 or one above period reloads period; `dir_down` is high.
- R4: In mode 3 (up-down), the count rises to period and then falls to 0, repeating. `dir_down` is the direction of the step that produced the present count. Each turning point gives exactly one event pulse.
- R5: `tez` (count now 0) and `tep` (count now equal to `period`) are high for exactly one cycle, aligned with the count value they describe. They appear only after an active tick. With `tick` low, the count and direction hold.
- R6: In mode 0 (held), the count and direction hold and no events fire, even while the counter is running.
- R7: Command 2 starts the counter and cancels any armed halt, so it runs with no automatic stop.
- R8: Commands 3 and 4 start the counter and halt it on the next zero event (3) or period event (4). The halted count stays at 0 or period, and no further events fire.
- R9: Commands 0 and 1 do not start a stopped counter. On a running counter they arm a halt at the next zero event (0) or period event (1).
- R10: Commands 5, 6 and 7 leave the run state and any armed halt unchanged. The mode field written with them still takes effect.
- R11: When a command write and an active tick fall in the same cycle, the tick uses the settings from before the write. A start command (2, 3 or 4) in that cycle keeps the counter running even if the tick's event would have halted it.
- R12: A mode written in a given cycle governs the ticks from the next cycle onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Clock enable; the counter may advance only in a cycle where it is high |
| period | input | 16 | Top of the count range |
| cfg_wr | input | 1 | Write strobe for `cfg_cmd` and `cfg_mode` |
| cfg_cmd | input | 3 | Start/stop command: 0/1 arm a halt at zero/period, 2 free run, 3/4 start and halt at zero/period, 5–7 no-op |
| cfg_mode | input | 2 | Counting mode: 0 held, 1 up, 2 down, 3 up-down |
| count | output | 16 | Present count |
| dir_down | output | 1 | High when the last step counted down |
| tez | output | 1 | One-cycle pulse: count has just become 0 |
| tep | output | 1 | One-cycle pulse: count has just become `period` |

## Verification
A command write and an active tick can fall in the same cycle, and so can the halt that the tick's event would cause. To provoke this, the bench arms a halt at the period event. It runs the count to one below period, then writes a free-run start together with the tick that reaches period. The expected result is a `tep` pulse followed by continued counting rather than a halt. The bench also changes the mode together with a tick and expects that tick to step in the old mode and the next tick in the new one.

// File: rtl/pwm_tbase_pkg.sv
package pwm_tbase_pkg;

  typedef enum logic [1:0] {
    CM_HOLD = 2'd0,
    CM_UP   = 2'd1,
    CM_DOWN = 2'd2,
    CM_UPDN = 2'd3
  } cnt_mode_e;

  typedef enum logic [1:0] {
    HALT_NONE = 2'd0,
    HALT_AT_Z = 2'd1,
    HALT_AT_P = 2'd2
  } halt_e;

  localparam logic [2:0] CMD_ARM_Z  = 3'd0;
  localparam logic [2:0] CMD_ARM_P  = 3'd1;
  localparam logic [2:0] CMD_FREE   = 3'd2;
  localparam logic [2:0] CMD_ONCE_Z = 3'd3;
  localparam logic [2:0] CMD_ONCE_P = 3'd4;

endpackage

// File: rtl/pwm_tbase_step.sv
module pwm_tbase_step
  import pwm_tbase_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] cnt,
  input  logic         down,
  input  logic [W-1:0] period,
  input  cnt_mode_e    mode,
  output logic [W-1:0] nxt,
  output logic         nxt_down,
  output logic         hit_z,
  output logic         hit_p
);

  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};
  localparam logic [W-1:0] ZERO = '0;

  logic at_zero, at_or_above_p, above_p, p_is_zero;

  assign at_zero       = (cnt == ZERO);
  assign at_or_above_p = (cnt >= period);
  assign above_p       = (cnt > period);
  assign p_is_zero     = (period == ZERO);

  always_comb begin
    nxt      = cnt;
    nxt_down = down;
    unique case (mode)
      CM_UP: begin
        nxt_down = 1'b0;
        nxt      = at_or_above_p ? ZERO : cnt + ONE;
      end
      CM_DOWN: begin
        nxt_down = 1'b1;
        nxt      = (at_zero || above_p) ? period : cnt - ONE;
      end
      CM_UPDN: begin
        if (!down) begin
          if (at_or_above_p) begin
            nxt_down = 1'b1;
            nxt      = at_zero ? ZERO : cnt - ONE;
          end else begin
            nxt = cnt + ONE;
          end
        end else begin
          if (at_zero) begin
            nxt_down = 1'b0;
            nxt      = p_is_zero ? ZERO : ONE;
          end else begin
            nxt = cnt - ONE;
          end
        end
      end
      default: begin
        nxt      = cnt;
        nxt_down = down;
      end
    endcase
  end

  assign hit_z = (nxt == ZERO);
  assign hit_p = (nxt == period);

endmodule

// File: rtl/pwm_tbase_runctl.sv
module pwm_tbase_runctl
  import pwm_tbase_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       cfg_wr,
  input  logic [2:0] cfg_cmd,
  input  logic [1:0] cfg_mode,
  input  logic       hit_z,
  input  logic       hit_p,
  output logic       adv,
  output logic       running,
  output cnt_mode_e  mode_q
);

  halt_e halt_q;
  logic  halt_now;
  logic  run_kept;
  halt_e halt_kept;

  assign adv = tick && running && (mode_q != CM_HOLD);

  assign halt_now = adv && (((halt_q == HALT_AT_Z) && hit_z) ||
                            ((halt_q == HALT_AT_P) && hit_p));
  assign run_kept  = running && !halt_now;
  assign halt_kept = halt_now ? HALT_NONE : halt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      halt_q  <= HALT_NONE;
      mode_q  <= CM_HOLD;
    end else if (cfg_wr) begin
      mode_q <= cnt_mode_e'(cfg_mode);
      unique case (cfg_cmd)
        CMD_ARM_Z: begin
          running <= run_kept;
          halt_q  <= HALT_AT_Z;
        end
        CMD_ARM_P: begin
          running <= run_kept;
          halt_q  <= HALT_AT_P;
        end
        CMD_FREE: begin
          running <= 1'b1;
          halt_q  <= HALT_NONE;
        end
        CMD_ONCE_Z: begin
          running <= 1'b1;
          halt_q  <= HALT_AT_Z;
        end
        CMD_ONCE_P: begin
          running <= 1'b1;
          halt_q  <= HALT_AT_P;
        end
        default: begin
          running <= run_kept;
          halt_q  <= halt_kept;
        end
      endcase
    end else begin
      running <= run_kept;
      halt_q  <= halt_kept;
    end
  end

endmodule

// File: rtl/pwm_tbase_cntreg.sv
module pwm_tbase_cntreg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  logic [W-1:0] nxt,
  input  logic         nxt_down,
  input  logic         hit_z,
  input  logic         hit_p,
  output logic [W-1:0] cnt,
  output logic         down,
  output logic         tez,
  output logic         tep
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      down <= 1'b0;
    end else if (adv) begin
      cnt  <= nxt;
      down <= nxt_down;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tez <= 1'b0;
      tep <= 1'b0;
    end else begin
      tez <= adv && hit_z;
      tep <= adv && hit_p;
    end
  end

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwm_tbase_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [W-1:0] period,
  input  logic         cfg_wr,
  input  logic [2:0]   cfg_cmd,
  input  logic [1:0]   cfg_mode,
  output logic [W-1:0] count,
  output logic         dir_down,
  output logic         tez,
  output logic         tep
);

  logic [W-1:0] nxt;
  logic         nxt_down;
  logic         hit_z, hit_p;
  logic         adv;
  logic         running;
  cnt_mode_e    mode_q;

  pwm_tbase_step #(.W(W)) u_step (
    .cnt      (count),
    .down     (dir_down),
    .period   (period),
    .mode     (mode_q),
    .nxt      (nxt),
    .nxt_down (nxt_down),
    .hit_z    (hit_z),
    .hit_p    (hit_p)
  );

  pwm_tbase_runctl u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .cfg_wr   (cfg_wr),
    .cfg_cmd  (cfg_cmd),
    .cfg_mode (cfg_mode),
    .hit_z    (hit_z),
    .hit_p    (hit_p),
    .adv      (adv),
    .running  (running),
    .mode_q   (mode_q)
  );

  pwm_tbase_cntreg #(.W(W)) u_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (adv),
    .nxt      (nxt),
    .nxt_down (nxt_down),
    .hit_z    (hit_z),
    .hit_p    (hit_p),
    .cnt      (count),
    .down     (dir_down),
    .tez      (tez),
    .tep      (tep)
  );

endmodule

// File: rtl/pwm_timebase_chk.sv
module pwm_timebase_chk
  import pwm_tbase_pkg::*;
#(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick,
  input logic [W-1:0] period,
  input logic         cfg_wr,
  input logic [W-1:0] count,
  input logic         dir_down,
  input logic         tez,
  input logic         tep,
  input logic         adv,
  input logic         running,
  input cnt_mode_e    mode_q
);

  AST_TEZ_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    tez |-> (count == '0)); // R5

  AST_TEP_AT_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    tep |-> (count == $past(period))); // R5

  AST_EVENT_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (tez || tep) |-> $past(tick)); // R5

  AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(count) && $stable(dir_down) && !tez && !tep)); // R5

  AST_FREEZE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == CM_HOLD) |=> ($stable(count) && !tez && !tep)); // R6

  AST_HALTED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !cfg_wr) |=> ($stable(count) && !tez && !tep && !running)); // R8

  AST_UP_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && mode_q == CM_UP) |=> !dir_down); // R2

  AST_DOWN_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && mode_q == CM_DOWN) |=> dir_down); // R3

  AST_UPDN_PEAK_TURN: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && mode_q == CM_UPDN && !dir_down && count == period && period != '0)
      |=> (dir_down && !tep)); // R4

endmodule

bind pwm_timebase pwm_timebase_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick     (tick),
  .period   (period),
  .cfg_wr   (cfg_wr),
  .count    (count),
  .dir_down (dir_down),
  .tez      (tez),
  .tep      (tep),
  .adv      (adv),
  .running  (running),
  .mode_q   (mode_q)
);

// File: tb/pwm_timebase_test.sv
module pwm_timebase_test;
  localparam int W = 16;
  localparam logic [W-1:0] P = 16'd5;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         tick = 1'b0;
  logic [W-1:0] period = P;
  logic         cfg_wr = 1'b0;
  logic [2:0]   cfg_cmd = 3'd0;
  logic [1:0]   cfg_mode = 2'd0;
  logic [W-1:0] count;
  logic         dir_down, tez, tep;

  int checks = 0;
  int fails = 0;

  pwm_timebase #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .period(period),
    .cfg_wr(cfg_wr), .cfg_cmd(cfg_cmd), .cfg_mode(cfg_mode),
    .count(count), .dir_down(dir_down), .tez(tez), .tep(tep)
  );

  always #4 clk = ~clk;

  // reference state, from the requirements
  logic [W-1:0] m_cnt = '0;
  logic         m_dn = 1'b0;
  logic         m_run = 1'b0;
  int           m_mode = 0;
  int           m_pend = 0;   // 0 none, 1 zero, 2 period

  logic [W+2:0] q_val[$];
  string        q_tag[$];

  task automatic drive(input logic t, input logic w, input logic [2:0] c,
                       input logic [1:0] md, input string tag);
    logic [W-1:0] nx;
    logic nd, adv, hz, hp, halt, ra;
    int pa;
    @(negedge clk);
    tick = t; cfg_wr = w; cfg_cmd = c; cfg_mode = md;
    adv = t && m_run && (m_mode != 0);
    nx = m_cnt; nd = m_dn;
    case (m_mode)
      1: begin nd = 1'b0; nx = (m_cnt >= period) ? '0 : m_cnt + 1'b1; end
      2: begin nd = 1'b1; nx = (m_cnt == 0 || m_cnt > period) ? period : m_cnt - 1'b1; end
      3: begin
        if (!m_dn) begin
          if (m_cnt >= period) begin nd = 1'b1; nx = (m_cnt == 0) ? '0 : m_cnt - 1'b1; end
          else nx = m_cnt + 1'b1;
        end else begin
          if (m_cnt == 0) begin nd = 1'b0; nx = (period == 0) ? '0 : 16'd1; end
          else nx = m_cnt - 1'b1;
        end
      end
      default: ;
    endcase
    hz = adv && (nx == 0);
    hp = adv && (nx == period);
    if (adv) begin m_cnt = nx; m_dn = nd; end
    halt = (m_pend == 1 && hz) || (m_pend == 2 && hp);
    ra = m_run && !halt;
    pa = halt ? 0 : m_pend;
    if (w) begin
      m_mode = int'(md);
      case (c)
        3'd0: begin m_run = ra;   m_pend = 1; end
        3'd1: begin m_run = ra;   m_pend = 2; end
        3'd2: begin m_run = 1'b1; m_pend = 0; end
        3'd3: begin m_run = 1'b1; m_pend = 1; end
        3'd4: begin m_run = 1'b1; m_pend = 2; end
        default: begin m_run = ra; m_pend = pa; end
      endcase
    end else begin
      m_run = ra; m_pend = pa;
    end
    q_val.push_back({m_cnt, m_dn, hz, hp});
    q_tag.push_back(tag);
  endtask

  task automatic ticks(input int n, input string tag);
    for (int i = 0; i < n; i++) drive(1'b1, 1'b0, 3'd0, 2'd0, tag);
  endtask

  task automatic cfg(input logic t, input logic [2:0] c, input logic [1:0] md, input string tag);
    drive(t, 1'b1, c, md, tag);
  endtask

  // monitor: pops one expectation per clock edge
  always @(posedge clk) begin
    #2;
    if (q_val.size() > 0) begin
      logic [W+2:0] e;
      string tg;
      e = q_val.pop_front();
      tg = q_tag.pop_front();
      checks++;
      if ({count, dir_down, tez, tep} !== e) begin
        fails++;
        $display("FAIL %s: actual cnt=%0d dn=%0b tez=%0b tep=%0b expected cnt=%0d dn=%0b tez=%0b tep=%0b",
                 tg, count, dir_down, tez, tep, e[W+2:3], e[2], e[1], e[0]);
      end
    end
  end

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog R1: actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    checks++;
    if ({count, dir_down, tez, tep} !== {16'd0, 3'b000}) begin
      fails++;
      $display("FAIL R1: actual cnt=%0d dn=%0b tez=%0b tep=%0b expected 0 0 0 0",
               count, dir_down, tez, tep);
    end
    ticks(3, "R1");
    cfg(1'b0, 3'd2, 2'd1, "R7");
    ticks(14, "R2");
    for (int i = 0; i < 5; i++) begin
      drive(1'b0, 1'b0, 3'd0, 2'd0, "R5");
      drive(1'b1, 1'b0, 3'd0, 2'd0, "R5");
    end
    cfg(1'b1, 3'd6, 2'd1, "R10");
    ticks(3, "R10");
    cfg(1'b0, 3'd2, 2'd2, "R3");
    ticks(14, "R3");
    cfg(1'b0, 3'd2, 2'd3, "R4");
    ticks(22, "R4");
    cfg(1'b0, 3'd2, 2'd0, "R6");
    ticks(5, "R6");
    cfg(1'b0, 3'd4, 2'd1, "R8");
    ticks(10, "R8");
    cfg(1'b0, 3'd3, 2'd1, "R8");
    ticks(10, "R8");
    cfg(1'b0, 3'd7, 2'd1, "R10");
    ticks(4, "R10");
    cfg(1'b0, 3'd1, 2'd1, "R9");
    ticks(3, "R9");
    cfg(1'b0, 3'd2, 2'd1, "R9");
    ticks(2, "R9");
    cfg(1'b0, 3'd1, 2'd1, "R9");
    ticks(8, "R9");
    cfg(1'b0, 3'd2, 2'd2, "R9");
    ticks(2, "R9");
    cfg(1'b0, 3'd0, 2'd2, "R9");
    ticks(8, "R9");
    cfg(1'b0, 3'd4, 2'd1, "R11");
    ticks(4, "R11");
    cfg(1'b1, 3'd2, 2'd1, "R11");
    ticks(4, "R11");
    cfg(1'b1, 3'd2, 2'd2, "R12");
    ticks(4, "R12");
    cfg(1'b1, 3'd2, 2'd3, "R12");
    ticks(6, "R4");
    drive(1'b0, 1'b0, 3'd0, 2'd0, "R5");
    repeat (2) @(posedge clk);
    #3;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule